// File: doc/BRIEF.md
# Shared interrupt routing controller

The controller gathers a parameterised set of level interrupt sources and steers each one to a selected processor and to one of that processor's interrupt pins. Every source owns four pieces of state: a pending flag, an enable flag, a pin route (a pin number plus a route flag) and a processor route (a valid bit plus a processor number). Each processor pin is the OR of the pending flags of all enabled sources routed to it. Each pin also includes that processor's local compare interrupt when the compare route selects that pin.

Software reaches the controller over a plain 32-bit word bus. The bus offers separate windows to set and clear enables, packed read-back of pending and enable flags, one pin-route word and one processor-route word per source, and a trigger word that forces any source's pending flag high or low. The word address is 11 bits. Bits [10:8] pick the window: 0 pending read, 1 enable read, 2 enable set, 3 enable clear, 4 trigger, 5 pin route, 6 processor route, 7 unused. Bits [7:0] give the word index inside the window.

Reads are served by a two-state bus machine. It sits in `ST_IDLE` until a read request arrives, which takes it to `ST_RESP`. In `ST_RESP` the captured word is presented with `bus_rvalid_o` high. From `ST_RESP`, a further read request keeps the machine in `ST_RESP`, and no request returns it to `ST_IDLE`. Writes take effect at the clock edge on which they are presented, in either state.

Top module: `irq_route_ctl`

## Requirements
- R1: After reset every source is disabled and not pending. Every pin-route word reads 0x8000_0000 (route flag set, pin 0). Every processor-route word reads 0. Every `irq_o` bit is 0.
- R2: A write to the enable-set window at word w sets the enable of source 32w+i for each 1 in bit i. Zero bits leave enables unchanged.
- R3: A write to the enable-clear window at word w clears the enable of source 32w+i for each 1 in bit i. Zero bits leave enables unchanged.
- R4: A read returns its data with `bus_rvalid_o` high in the cycle after the request. Pending and enable words pack sources so that bit i of word w is source 32w+i. Bits for sources at or above NUM_SRC read 0.
- R5: `irq_o[v*NUM_PIN+p]` is the OR of the pending flags of all enabled sources that are routed to processor v and pin p.
- R6: A disabled source drives no output, even while it is pending.
- R7: The same output also goes high when `cmp_irq_i[v]` and `cmp_en_i[v]` are both set and `cmp_pin_i[v*PIN_W +: PIN_W]` equals p.
- R8: In a pin-route word, bit 31 is the route flag and bits [5:0] are the pin number. A write whose pin number exceeds NUM_PIN-1 changes nothing. Reads return the route flag in bit 31 and the pin in the low bits.
- R9: A processor-route write takes the lowest set bit of the data as the processor number. Writing 0 unmaps the source. A write whose lowest set bit is at or above NUM_VP changes nothing. Reads return 1 shifted left by the processor number, or 0 when the source is unmapped.
- R10: The trigger word lives at window 4, index 0. Its bit 31 is the level and bits [30:0] are the source number, and the write sets that source's pending flag to the level. A source number at or above NUM_SRC is ignored. In the same cycle, a trigger write wins over an input change on the same source.
- R11: When `src_i[s]` differs from its value on the previous clock, the pending flag of source s takes the new level at that edge.
- R12: Writes to word indices beyond the configured source range are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write request, applied at this edge |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | 11 | Word address: window in [10:8], index in [7:0] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | High in the cycle after a read request |
| src_i | input | NUM_SRC | External source levels |
| cmp_irq_i | input | NUM_VP | Local compare interrupt per processor |
| cmp_en_i | input | NUM_VP | Local compare mask per processor |
| cmp_pin_i | input | NUM_VP*PIN_W | Local compare pin route per processor |
| irq_o | output | NUM_VP*NUM_PIN | One line per processor pin |

## Verification
Sources are routed to different processors and pins, including two sources sharing one output. Removing one of those two shows that the OR keeps the line high, which a plain last-writer design would not. A source is made pending while disabled and then enabled, which separates the enable gate from the pending state. Each route word is written with accepted values and with rejected ones (pin 6, a one-hot bit above the processor count, zero), and read back to show that rejection leaves the old route in place. Trigger writes are aimed both inside and outside the source range, and once together with an input change on the same source, which shows the priority between the two update paths.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 8;
    localparam int unsigned ADDR_W = 11;
    localparam int unsigned PINF_W = 6;

    typedef enum logic [2:0] {
        RG_PEND  = 3'd0,
        RG_EN    = 3'd1,
        RG_SET   = 3'd2,
        RG_CLR   = 3'd3,
        RG_WEDGE = 3'd4,
        RG_PIN   = 3'd5,
        RG_VP    = 3'd6,
        RG_NONE  = 3'd7
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic wedge;
        logic pin;
        logic vp;
    } wr_strobe_t;

    function automatic logic [5:0] lsb_index(input logic [DATA_W-1:0] v);
        logic [5:0] r;
        r = 6'd32;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_route_bus.sv
`timescale 1ns/1ps
module irq_route_bus
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 256,
    parameter int PIN_W   = 3,
    parameter int VP_W    = 1
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_i,
    input  logic                            rd_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [NUM_SRC-1:0]              pend_i,
    input  logic [NUM_SRC-1:0]              en_i,
    input  logic [NUM_SRC-1:0]              route_i,
    input  logic [NUM_SRC-1:0]              vld_i,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]   pin_i,
    input  logic [NUM_SRC-1:0][VP_W-1:0]    vp_i,
    output wr_strobe_t                      stb_o,
    output logic [IDX_W-1:0]                idx_o,
    output logic [DATA_W-1:0]               rdata_o,
    output logic                            rvalid_o
);
    localparam int NW = (NUM_SRC + DATA_W - 1) / DATA_W;

    region_e             region;
    logic [IDX_W-1:0]    idx;
    logic [NW*DATA_W-1:0] pend_pad, en_pad;
    logic [DATA_W-1:0]   rd_word, rdata_q;
    bus_state_e          state_q, state_d;

    assign region = region_e'(addr_i[ADDR_W-1:IDX_W]);
    assign idx    = addr_i[IDX_W-1:0];
    assign idx_o  = idx;

    always_comb begin
        stb_o.set   = wr_i && (region == RG_SET);
        stb_o.clr   = wr_i && (region == RG_CLR);
        stb_o.wedge = wr_i && (region == RG_WEDGE) && (idx == '0);
        stb_o.pin   = wr_i && (region == RG_PIN);
        stb_o.vp    = wr_i && (region == RG_VP);
    end

    always_comb begin
        pend_pad = '0;
        en_pad   = '0;
        pend_pad[NUM_SRC-1:0] = pend_i;
        en_pad[NUM_SRC-1:0]   = en_i;
    end

    always_comb begin
        rd_word = '0;
        unique case (region)
            RG_PEND: begin
                for (int w = 0; w < NW; w++)
                    if (idx == IDX_W'(w)) rd_word = pend_pad[w*DATA_W +: DATA_W];
            end
            RG_EN: begin
                for (int w = 0; w < NW; w++)
                    if (idx == IDX_W'(w)) rd_word = en_pad[w*DATA_W +: DATA_W];
            end
            RG_PIN: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (idx == IDX_W'(s))
                        rd_word = {route_i[s], {(DATA_W-1-PIN_W){1'b0}}, pin_i[s]};
            end
            RG_VP: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (idx == IDX_W'(s) && vld_i[s])
                        rd_word = DATA_W'(1) << vp_i[s];
            end
            default: rd_word = '0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_i) state_d = ST_RESP;
            ST_RESP: state_d = rd_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_word;
    end

    // outputs
    always_comb begin
        rvalid_o = 1'b0;
        rdata_o  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rvalid_o = 1'b1;
                rdata_o  = rdata_q;
            end
            default: ;
        endcase
    end

    a_r4_read_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> rvalid_o);

    a_r4_no_read_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> !rvalid_o);

    a_r12_oob_route_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && (region == RG_PIN || region == RG_VP) && int'(idx) >= NUM_SRC)
        |=> (rdata_o == '0));
endmodule

// File: rtl/irq_route_bank.sv
`timescale 1ns/1ps
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 256,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    parameter int PIN_W   = 3,
    parameter int VP_W    = 1
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [NUM_SRC-1:0]              src_i,
    input  wr_strobe_t                      stb_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [NUM_SRC-1:0]              pend_o,
    output logic [NUM_SRC-1:0]              en_o,
    output logic [NUM_SRC-1:0]              route_o,
    output logic [NUM_SRC-1:0]              vld_o,
    output logic [NUM_SRC-1:0][PIN_W-1:0]   pin_o,
    output logic [NUM_SRC-1:0][VP_W-1:0]    vp_o
);
    logic [NUM_SRC-1:0] src_q;
    logic [30:0]        wedge_num;
    logic               pin_ok, vp_ok, vp_zero;
    logic [5:0]         low_bit;

    assign wedge_num = wdata_i[30:0];
    assign pin_ok    = wdata_i[PINF_W-1:0] <= PINF_W'(NUM_PIN - 1);
    assign low_bit   = lsb_index(wdata_i);
    assign vp_ok     = int'(low_bit) < NUM_VP;
    assign vp_zero   = (wdata_i == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) src_q <= '0;
        else         src_q <= src_i;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int WORD = s / DATA_W;
        localparam int BITP = s % DATA_W;
        logic hit_idx;
        assign hit_idx = (idx_i == IDX_W'(s));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pend_o[s]  <= 1'b0;
                en_o[s]    <= 1'b0;
                route_o[s] <= 1'b1;
                pin_o[s]   <= '0;
                vld_o[s]   <= 1'b0;
                vp_o[s]    <= '0;
            end else begin
                if (stb_i.wedge && wedge_num == 31'(s))
                    pend_o[s] <= wdata_i[31];
                else if (src_i[s] != src_q[s])
                    pend_o[s] <= src_i[s];

                if (stb_i.set && idx_i == IDX_W'(WORD) && wdata_i[BITP])
                    en_o[s] <= 1'b1;
                else if (stb_i.clr && idx_i == IDX_W'(WORD) && wdata_i[BITP])
                    en_o[s] <= 1'b0;

                if (stb_i.pin && hit_idx && pin_ok) begin
                    route_o[s] <= wdata_i[31];
                    pin_o[s]   <= wdata_i[PIN_W-1:0];
                end

                if (stb_i.vp && hit_idx) begin
                    if (vp_zero) begin
                        vld_o[s] <= 1'b0;
                    end else if (vp_ok) begin
                        vld_o[s] <= 1'b1;
                        vp_o[s]  <= low_bit[VP_W-1:0];
                    end
                end
            end
        end

        a_r3_clear_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stb_i.clr && idx_i == IDX_W'(WORD) && wdata_i[BITP]) |=> !en_o[s]);

        a_r8_bad_pin_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stb_i.pin && hit_idx && wdata_i[PINF_W-1:0] > PINF_W'(NUM_PIN - 1))
            |=> ($stable(pin_o[s]) && $stable(route_o[s])));

        a_r9_zero_unmaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stb_i.vp && hit_idx && wdata_i == '0) |=> !vld_o[s]);
    end

    a_r10_wedge_oob_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i.wedge && int'(wedge_num) >= NUM_SRC && src_i == src_q) |=> $stable(pend_o));
endmodule

// File: rtl/irq_route_merge.sv
`timescale 1ns/1ps
module irq_route_merge #(
    parameter int NUM_SRC = 256,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    parameter int PIN_W   = 3,
    parameter int VP_W    = 1
) (
    input  logic [NUM_SRC-1:0]              pend_i,
    input  logic [NUM_SRC-1:0]              en_i,
    input  logic [NUM_SRC-1:0]              vld_i,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]   pin_i,
    input  logic [NUM_SRC-1:0][VP_W-1:0]    vp_i,
    input  logic [NUM_VP-1:0]               cmp_irq_i,
    input  logic [NUM_VP-1:0]               cmp_en_i,
    input  logic [NUM_VP*PIN_W-1:0]         cmp_pin_i,
    output logic [NUM_VP*NUM_PIN-1:0]       irq_o
);
    logic [NUM_SRC-1:0] live;
    assign live = pend_i & en_i & vld_i;

    for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            always_comb begin
                logic acc;
                acc = cmp_irq_i[v] && cmp_en_i[v] &&
                      (cmp_pin_i[v*PIN_W +: PIN_W] == PIN_W'(p));
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (live[s] && vp_i[s] == VP_W'(v) && pin_i[s] == PIN_W'(p))
                        acc = 1'b1;
                end
                irq_o[v*NUM_PIN + p] = acc;
            end
        end
    end
endmodule

// File: rtl/irq_route_ctl.sv
`timescale 1ns/1ps
module irq_route_ctl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 256,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    parameter int PIN_W   = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    parameter int VP_W    = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        bus_wr_i,
    input  logic                        bus_rd_i,
    input  logic [10:0]                 bus_addr_i,
    input  logic [31:0]                 bus_wdata_i,
    output logic [31:0]                 bus_rdata_o,
    output logic                        bus_rvalid_o,
    input  logic [NUM_SRC-1:0]          src_i,
    input  logic [NUM_VP-1:0]           cmp_irq_i,
    input  logic [NUM_VP-1:0]           cmp_en_i,
    input  logic [NUM_VP*PIN_W-1:0]     cmp_pin_i,
    output logic [NUM_VP*NUM_PIN-1:0]   irq_o
);
    wr_strobe_t                     stb;
    logic [IDX_W-1:0]               idx;
    logic [NUM_SRC-1:0]             pend, en, route, vld;
    logic [NUM_SRC-1:0][PIN_W-1:0]  pin;
    logic [NUM_SRC-1:0][VP_W-1:0]   vp;

    irq_route_bus #(.NUM_SRC(NUM_SRC), .PIN_W(PIN_W), .VP_W(VP_W)) u_bus (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
        .addr_i(bus_addr_i), .pend_i(pend), .en_i(en), .route_i(route),
        .vld_i(vld), .pin_i(pin), .vp_i(vp), .stb_o(stb), .idx_o(idx),
        .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
    );

    irq_route_bank #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN),
                     .PIN_W(PIN_W), .VP_W(VP_W)) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .stb_i(stb),
        .idx_i(idx), .wdata_i(bus_wdata_i), .pend_o(pend), .en_o(en),
        .route_o(route), .vld_o(vld), .pin_o(pin), .vp_o(vp)
    );

    irq_route_merge #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN),
                      .PIN_W(PIN_W), .VP_W(VP_W)) u_merge (
        .pend_i(pend), .en_i(en), .vld_i(vld), .pin_i(pin), .vp_i(vp),
        .cmp_irq_i(cmp_irq_i), .cmp_en_i(cmp_en_i), .cmp_pin_i(cmp_pin_i),
        .irq_o(irq_o)
    );

    a_r6_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en == '0 && cmp_en_i == '0) |-> (irq_o == '0));
endmodule

// File: tb/test_irq_route_ctl.sv
`timescale 1ns/1ps
module test_irq_route_ctl;
    localparam int NS  = 40;
    localparam int NVP = 2;
    localparam int NP  = 6;
    localparam int PW  = 3;
    localparam int NW  = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_rvalid;
    logic [NS-1:0] src = '0;
    logic [NVP-1:0] cmp_irq = '0, cmp_en = '0;
    logic [NVP*PW-1:0] cmp_pin = '0;
    logic [NVP*NP-1:0] irq;

    int n_checks = 0, n_err = 0;
    string cur_tag = "R4";

    bit m_pend[NS], m_en[NS], m_route[NS], m_vld[NS], m_srcq[NS];
    int m_pin[NS], m_vp[NS];
    bit m_rv = 0;
    logic [31:0] m_rd = '0;

    irq_route_ctl #(.NUM_SRC(NS), .NUM_VP(NVP), .NUM_PIN(NP)) i_irq_route_ctl (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .bus_rvalid_o(bus_rvalid), .src_i(src), .cmp_irq_i(cmp_irq),
        .cmp_en_i(cmp_en), .cmp_pin_i(cmp_pin), .irq_o(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [10:0] a);
        logic [31:0] r;
        int rg, ix;
        r  = '0;
        rg = int'(a[10:8]);
        ix = int'(a[7:0]);
        if ((rg == 0 || rg == 1) && ix < NW) begin
            for (int b = 0; b < 32; b++) begin
                if (ix*32 + b < NS) r[b] = (rg == 0) ? m_pend[ix*32+b] : m_en[ix*32+b];
            end
        end else if (rg == 5 && ix < NS) begin
            r = (32'(m_route[ix]) << 31) | 32'(m_pin[ix]);
        end else if (rg == 6 && ix < NS && m_vld[ix]) begin
            r = 32'd1 << m_vp[ix];
        end
        return r;
    endfunction

    function automatic logic [NVP*NP-1:0] model_irq();
        logic [NVP*NP-1:0] r;
        r = '0;
        for (int v = 0; v < NVP; v++) begin
            for (int p = 0; p < NP; p++) begin
                if (cmp_irq[v] && cmp_en[v] && int'(cmp_pin[v*PW +: PW]) == p) r[v*NP+p] = 1'b1;
                for (int s = 0; s < NS; s++)
                    if (m_pend[s] && m_en[s] && m_vld[s] && m_vp[s] == v && m_pin[s] == p)
                        r[v*NP+p] = 1'b1;
            end
        end
        return r;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                m_pend[s] = 0; m_en[s] = 0; m_route[s] = 1; m_pin[s] = 0;
                m_vld[s] = 0; m_vp[s] = 0; m_srcq[s] = 0;
            end
            m_rv = 0;
        end else begin
            int rg, ix, d5, lo;
            m_rv = bus_rd;
            if (bus_rd) m_rd = model_read(bus_addr);
            for (int s = 0; s < NS; s++) begin
                if (src[s] != m_srcq[s]) m_pend[s] = src[s];
                m_srcq[s] = src[s];
            end
            if (bus_wr) begin
                rg = int'(bus_addr[10:8]);
                ix = int'(bus_addr[7:0]);
                if ((rg == 2 || rg == 3) && ix < NW) begin
                    for (int b = 0; b < 32; b++)
                        if (ix*32 + b < NS && bus_wdata[b]) m_en[ix*32+b] = (rg == 2);
                end
                if (rg == 4 && ix == 0 && int'(bus_wdata[30:0]) < NS)
                    m_pend[int'(bus_wdata[30:0])] = bus_wdata[31];
                if (rg == 5 && ix < NS) begin
                    d5 = int'(bus_wdata[5:0]);
                    if (d5 <= NP - 1) begin
                        m_pin[ix] = d5;
                        m_route[ix] = bus_wdata[31];
                    end
                end
                if (rg == 6 && ix < NS) begin
                    if (bus_wdata == 0) m_vld[ix] = 0;
                    else begin
                        lo = 0;
                        while (!bus_wdata[lo]) lo++;
                        if (lo < NVP) begin m_vld[ix] = 1; m_vp[ix] = lo; end
                    end
                end
            end
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        chk("R5", 32'(irq), 32'(model_irq()));
        chk("R4", 32'(bus_rvalid), 32'(m_rv));
        if (m_rv) chk(cur_tag, bus_rdata, m_rd);
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    function automatic logic [10:0] A(input int rg, input int ix);
        return {3'(rg), 8'(ix)};
    endfunction

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input string tag);
        bus_rd = 1'b1; bus_addr = a; cur_tag = tag;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic rd_exp(input logic [10:0] a, input string tag, input logic [31:0] e);
        rd(a, tag);
        settle();
        chk(tag, bus_rdata, e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        settle(); chk("R1", 32'(irq), 32'd0);
        rd_exp(A(0,0), "R1", 32'd0);
        rd_exp(A(1,1), "R1", 32'd0);
        rd_exp(A(5,0), "R1", 32'h8000_0000);
        rd_exp(A(6,39), "R1", 32'd0);

        // source 3 -> vp1 pin2, pending while disabled
        wr(A(5,3), 32'h8000_0002);
        wr(A(6,3), 32'h0000_0002);
        wr(A(4,0), 32'h8000_0003);
        settle(); chk("R6", 32'(irq[1*NP+2]), 32'd0);
        rd_exp(A(0,0), "R4", 32'h0000_0008);
        wr(A(2,0), 32'h0000_0008);
        settle(); chk("R5", 32'(irq[1*NP+2]), 32'd1);
        rd_exp(A(1,0), "R2", 32'h0000_0008);

        // source 35 via input, vp0 pin5
        src[35] = 1'b1;
        tick(); tick();
        rd_exp(A(0,1), "R11", 32'h0000_0008);
        wr(A(5,35), 32'h0000_0005);
        wr(A(6,35), 32'h0000_0005);
        wr(A(2,1), 32'h0000_0008);
        settle(); chk("R5", 32'(irq[0*NP+5]), 32'd1);
        rd_exp(A(6,35), "R9", 32'h0000_0001);
        wr(A(6,35), 32'h0000_0004);
        rd_exp(A(6,35), "R9", 32'h0000_0001);
        src[35] = 1'b0;
        tick(); tick();
        settle(); chk("R11", 32'(irq[0*NP+5]), 32'd0);

        // pin route rejection and acceptance
        wr(A(5,3), 32'h0000_0006);
        rd_exp(A(5,3), "R8", 32'h8000_0002);
        wr(A(5,3), 32'h0000_0004);
        rd_exp(A(5,3), "R8", 32'h0000_0004);
        settle(); chk("R8", 32'(irq[1*NP+4]), 32'd1);

        // shared output OR: source 4 also to vp1 pin4
        wr(A(5,4), 32'h0000_0004);
        wr(A(6,4), 32'h0000_0006);
        wr(A(2,0), 32'h0000_0010);
        wr(A(4,0), 32'h8000_0004);
        wr(A(4,0), 32'h0000_0003);
        settle(); chk("R5", 32'(irq[1*NP+4]), 32'd1);
        wr(A(3,0), 32'h0000_0010);
        settle(); chk("R3", 32'(irq[1*NP+4]), 32'd0);
        rd_exp(A(1,0), "R3", 32'h0000_0008);
        wr(A(2,0), 32'h0000_0000);
        rd_exp(A(1,0), "R2", 32'h0000_0008);

        // out-of-range trigger numbers
        wr(A(4,0), 32'h8000_0028);
        wr(A(4,0), 32'h8000_00FF);
        rd_exp(A(0,0), "R10", 32'h0000_0010);
        rd_exp(A(0,1), "R10", 32'h0000_0000);

        // trigger wins over simultaneous input change
        src[7] = 1'b1;
        wr(A(4,0), 32'h0000_0007);
        rd_exp(A(0,0), "R10", 32'h0000_0010);

        // out-of-range indices
        wr(A(5,45), 32'h0000_0001);
        rd_exp(A(5,45), "R12", 32'd0);
        rd_exp(A(0,2), "R12", 32'd0);
        wr(A(2,2), 32'hFFFF_FFFF);
        rd_exp(A(1,2), "R12", 32'd0);
        rd_exp(A(6,200), "R12", 32'd0);

        // local compare interrupt
        cmp_pin = {3'd3, 3'd1};
        cmp_irq = 2'b11;
        tick();
        settle(); chk("R7", 32'(irq), 32'd0);
        cmp_en = 2'b10;
        tick();
        settle(); chk("R7", 32'(irq), 32'h0000_0200);
        cmp_en = 2'b00;
        tick();

        // unmapping via zero
        wr(A(2,0), 32'h0000_0008);
        wr(A(4,0), 32'h8000_0003);
        settle(); chk("R9", 32'(irq[1*NP+4]), 32'd1);
        wr(A(6,3), 32'h0000_0000);
        rd_exp(A(6,3), "R9", 32'd0);
        settle(); chk("R9", 32'(irq[1*NP+4]), 32'd0);

        tick();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule